// File: doc/BRIEF.md
# Calendar Timekeeper with Write-Busy Flags

This block is a memory-mapped real-time clock core. It counts seconds, minutes and hours, and a calendar date made of day of month, month and a year offset from a base year. A one-cycle tick pulse, produced elsewhere once per second, advances the count. Software reaches the block through a small register port: one word holds the time, one holds the date and one holds the write-busy flags.

Writes to the time or date word do not take effect at once. The written value waits in a staging register for a fixed number of system clock cycles before it replaces the live count. A busy flag for each word stays set for the whole of that delay. Ticks that arrive while any commit is in flight are held back and applied once the commit has landed, so a freshly written value is never overwritten by a stale increment. The date word also carries a leap-year flag. Software sets this flag, and the calendar uses it only to decide whether February has 28 or 29 days.

Software is expected to write the time, wait for its busy flag to clear, then write the date. The time and date may roll over between two reads, so a consistent pair is obtained by reading both twice and comparing the results.

Top module: `rtc_cal_core`

## Requirements
- R1: After reset the control word reads 0, the time word reads 0 and the date word reads 0x00000101 (day 1, month 1, year offset 0, leap flag 0).
- R2: The control word is at offset 0x0, the date word at 0x4 and the time word at 0x8. Every read returns its data with `rvalid_o` high on the cycle after the request. A read of any other offset returns 0.
- R3: The time word holds seconds in [5:0], minutes in [13:8] and hours in [20:16]. On each applied tick, seconds step from 59 to 0 and carry into minutes. Minutes step from 59 to 0 and carry into hours. Hours step from 23 to 0 and carry into the day.
- R4: A write to the time word sets control bit 8 from the next cycle. The bit stays set for COMMIT_CYC cycles and then clears. While it is set, reads of the time word return the old value. The written value is readable from the cycle in which the bit clears.
- R5: A write to the date word sets control bit 7 in the same way and for the same length of time. It does not touch bit 8.
- R6: The date word holds day in [4:0] and month (1 to 12) in [11:8]. Day 31 is the last day of months 1, 3, 5, 7, 8, 10 and 12, and day 30 is the last day of months 4, 6, 9 and 11. A carry past the last day sets day 1 of the next month.
- R7: The leap flag is bit 24 of the date word. February ends on day 29 when the flag is 1 and on day 28 when it is 0. Rollovers never change the flag.
- R8: The year offset is held in [23:16]. A carry out of month 12 sets month 1 and increments the offset, and offset 255 wraps to 0.
- R9: A tick that arrives while either busy flag is set is not lost. It is applied after the commit completes, so it acts on the newly written value.
- R10: Writes to the control word or to an unmapped offset change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the word |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |

## Verification
The counter chain is started from loaded values and ticked through specific transitions:
- a plain seconds step;
- a minute carry and an hour carry that leave the date alone;
- the end of a 30-day month and the end of a 31-day month, plus the day just before a 31-day end;
- February with the leap flag clear and with it set;
- the year end at a mid-range offset and at the offset that wraps.

These cases separate a wrong month-length choice from a wrong carry chain. The commit path is checked by reading the busy flags and the old value cycle by cycle through the window, which exposes an off-by-one in the delay. Ticks placed inside time and date commit windows show whether a held-back tick is dropped or applied to the stale value.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int SEC_W = 6;
  localparam int MIN_W = 6;
  localparam int HR_W  = 5;
  localparam int DAY_W = 5;
  localparam int MON_W = 4;

  // register offsets and field positions decoded by software
  localparam int OFF_CTRL = 'h0;
  localparam int OFF_DATE = 'h4;
  localparam int OFF_TIME = 'h8;

  localparam int SEC_LSB  = 0;
  localparam int MIN_LSB  = 8;
  localparam int HR_LSB   = 16;
  localparam int DAY_LSB  = 0;
  localparam int MON_LSB  = 8;
  localparam int YEAR_LSB = 16;

  localparam int DBUSY_BIT = 7;
  localparam int TBUSY_BIT = 8;

  localparam int CH_TIME = 0;
  localparam int CH_DATE = 1;
  localparam int NUM_CH  = 2;

  localparam logic [SEC_W-1:0] SEC_MAX = SEC_W'(59);
  localparam logic [MIN_W-1:0] MIN_MAX = MIN_W'(59);
  localparam logic [HR_W-1:0]  HR_MAX  = HR_W'(23);
  localparam logic [MON_W-1:0] MON_MAX = MON_W'(12);

  typedef struct packed {
    logic [HR_W-1:0]  hr;
    logic [MIN_W-1:0] min;
    logic [SEC_W-1:0] sec;
  } hms_t;

  function automatic logic [DAY_W-1:0] month_last_day(input logic [MON_W-1:0] mon,
                                                      input logic leap);
    logic [DAY_W-1:0] d;
    case (mon)
      MON_W'(2):                                   d = leap ? DAY_W'(29) : DAY_W'(28);
      MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11): d = DAY_W'(30);
      default:                                     d = DAY_W'(31);
    endcase
    return d;
  endfunction

endpackage

// File: rtl/rtc_wrap_cnt.sv
// Loadable counter that wraps to LO once it reaches max_i on an increment.
module rtc_wrap_cnt #(
  parameter int W  = 6,
  parameter int LO = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  input  logic [W-1:0] max_i,
  output logic [W-1:0] val_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] LoVal = W'(LO);

  logic [W-1:0] val_q;

  // >= so an out-of-range loaded value still recovers
  assign wrap_o = inc_i && (val_q >= max_i);
  assign val_o  = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= LoVal;
    else if (load_i) val_q <= load_val_i;
    else if (inc_i)  val_q <= wrap_o ? LoVal : val_q + 1'b1;
  end

endmodule

// File: rtl/rtc_commit_ctl.sv
// Fixed-length commit window: busy for CYC cycles, done on the last one.
module rtc_commit_ctl #(
  parameter int CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] CntInit = CW'(CYC);

  logic [CW-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1)) && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= CntInit;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  a_r4_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);

  a_r4_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

endmodule

// File: rtl/rtc_cal_core.sv
module rtc_cal_core
  import rtc_cal_pkg::*;
#(
  parameter int COMMIT_CYC = 4,
  parameter int YEAR_W     = 8,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam int LEAP_BIT = YEAR_LSB + YEAR_W;
  localparam logic [ADDR_W-1:0] ACtrl = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] ADate = ADDR_W'(OFF_DATE);
  localparam logic [ADDR_W-1:0] ATime = ADDR_W'(OFF_TIME);
  localparam logic [YEAR_W-1:0] YearMax = {YEAR_W{1'b1}};

  // ---------------- register port decode ----------------
  logic wr_time, wr_date;
  assign wr_time = req_i && we_i && (addr_i == ATime);
  assign wr_date = req_i && we_i && (addr_i == ADate);

  logic wdata_unused;
  assign wdata_unused = ^wdata_i;

  // ---------------- commit channels ----------------
  logic [NUM_CH-1:0] start, busy, done;
  assign start[CH_TIME] = wr_time;
  assign start[CH_DATE] = wr_date;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_commit
    rtc_commit_ctl #(.CYC(COMMIT_CYC)) u_ctl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start[g]),
      .busy_o  (busy[g]),
      .done_o  (done[g])
    );
  end

  logic any_busy;
  assign any_busy = |busy;

  // ---------------- staging registers ----------------
  hms_t              stg_t;
  logic [DAY_W-1:0]  stg_day;
  logic [MON_W-1:0]  stg_mon;
  logic [YEAR_W-1:0] stg_yr;
  logic              stg_leap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_t    <= '0;
      stg_day  <= DAY_W'(1);
      stg_mon  <= MON_W'(1);
      stg_yr   <= '0;
      stg_leap <= 1'b0;
    end else begin
      if (wr_time) begin
        stg_t.sec <= wdata_i[SEC_LSB +: SEC_W];
        stg_t.min <= wdata_i[MIN_LSB +: MIN_W];
        stg_t.hr  <= wdata_i[HR_LSB +: HR_W];
      end
      if (wr_date) begin
        stg_day  <= wdata_i[DAY_LSB +: DAY_W];
        stg_mon  <= wdata_i[MON_LSB +: MON_W];
        stg_yr   <= wdata_i[YEAR_LSB +: YEAR_W];
        stg_leap <= wdata_i[LEAP_BIT];
      end
    end
  end

  logic leap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             leap_q <= 1'b0;
    else if (done[CH_DATE])  leap_q <= stg_leap;
  end

  // ---------------- tick hold-off ----------------
  logic tick_pend_q, tick_go;
  assign tick_go = (tick_i || tick_pend_q) && !any_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tick_pend_q <= 1'b0;
    else if (tick_go) tick_pend_q <= 1'b0;
    else if (tick_i)  tick_pend_q <= 1'b1;
  end

  // ---------------- counter chain ----------------
  logic [SEC_W-1:0]  sec_q;
  logic [MIN_W-1:0]  min_q;
  logic [HR_W-1:0]   hr_q;
  logic [DAY_W-1:0]  day_q;
  logic [MON_W-1:0]  mon_q;
  logic [YEAR_W-1:0] yr_q;
  logic sec_wrap, min_wrap, hr_wrap, day_wrap, mon_wrap, yr_wrap;
  logic [DAY_W-1:0] day_max;

  assign day_max = month_last_day(mon_q, leap_q);

  rtc_wrap_cnt #(.W(SEC_W), .LO(0)) u_sec (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(done[CH_TIME]), .load_val_i(stg_t.sec),
    .inc_i(tick_go), .max_i(SEC_MAX), .val_o(sec_q), .wrap_o(sec_wrap));

  rtc_wrap_cnt #(.W(MIN_W), .LO(0)) u_min (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(done[CH_TIME]), .load_val_i(stg_t.min),
    .inc_i(sec_wrap), .max_i(MIN_MAX), .val_o(min_q), .wrap_o(min_wrap));

  rtc_wrap_cnt #(.W(HR_W), .LO(0)) u_hr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(done[CH_TIME]), .load_val_i(stg_t.hr),
    .inc_i(min_wrap), .max_i(HR_MAX), .val_o(hr_q), .wrap_o(hr_wrap));

  rtc_wrap_cnt #(.W(DAY_W), .LO(1)) u_day (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(done[CH_DATE]), .load_val_i(stg_day),
    .inc_i(hr_wrap), .max_i(day_max), .val_o(day_q), .wrap_o(day_wrap));

  rtc_wrap_cnt #(.W(MON_W), .LO(1)) u_mon (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(done[CH_DATE]), .load_val_i(stg_mon),
    .inc_i(day_wrap), .max_i(MON_MAX), .val_o(mon_q), .wrap_o(mon_wrap));

  rtc_wrap_cnt #(.W(YEAR_W), .LO(0)) u_yr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(done[CH_DATE]), .load_val_i(stg_yr),
    .inc_i(mon_wrap), .max_i(YearMax), .val_o(yr_q), .wrap_o(yr_wrap));

  logic yr_wrap_unused;
  assign yr_wrap_unused = yr_wrap;

  // ---------------- read path ----------------
  logic [DATA_W-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    case (addr_i)
      ACtrl: begin
        rd_word[TBUSY_BIT] = busy[CH_TIME];
        rd_word[DBUSY_BIT] = busy[CH_DATE];
      end
      ATime: begin
        rd_word[SEC_LSB +: SEC_W] = sec_q;
        rd_word[MIN_LSB +: MIN_W] = min_q;
        rd_word[HR_LSB +: HR_W]   = hr_q;
      end
      ADate: begin
        rd_word[DAY_LSB +: DAY_W]   = day_q;
        rd_word[MON_LSB +: MON_W]   = mon_q;
        rd_word[YEAR_LSB +: YEAR_W] = yr_q;
        rd_word[LEAP_BIT]           = leap_q;
      end
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= req_i && !we_i;
      if (req_i && !we_i) rdata_o <= rd_word;
    end
  end

  // ---------------- assertions ----------------
  a_r2_read_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  a_r3_sec_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_go && sec_q == SEC_MAX) |=> (sec_q == '0) && !$stable(min_q));

  a_r8_year_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_wrap && mon_q == MON_MAX) |=>
      (mon_q == MON_W'(1)) && (yr_q == YEAR_W'($past(yr_q) + 1'b1)));

  a_r9_hold_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_busy && !done[CH_TIME]) |=> $stable(sec_q));

  a_r7_leap_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done[CH_DATE] |=> $stable(leap_q));

endmodule

// File: tb/sim_rtc_cal_core.sv
module sim_rtc_cal_core;
  localparam int CYC = 4;
  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_DATE = 4'h4;
  localparam logic [3:0] A_TIME = 4'h8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;

  always #10 clk = ~clk;  // 50 MHz

  rtc_cal_core #(.COMMIT_CYC(CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid));

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  // reference calendar
  int m_sec, m_min, m_hr, m_day, m_mon, m_yr;
  bit m_leap;

  function automatic int mlen(int mo, bit lp);
    case (mo)
      2: return lp ? 29 : 28;
      4, 6, 9, 11: return 30;
      default: return 31;
    endcase
  endfunction

  function automatic void model_tick();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hr++;
        if (m_hr == 24) begin
          m_hr = 0; m_day++;
          if (m_day > mlen(m_mon, m_leap)) begin
            m_day = 1; m_mon++;
            if (m_mon == 13) begin
              m_mon = 1; m_yr = (m_yr + 1) % 256;
            end
          end
        end
      end
    end
  endfunction

  function automatic logic [31:0] pk_time(int h, int mi, int s);
    logic [31:0] w = '0;
    w[20:16] = 5'(h); w[13:8] = 6'(mi); w[5:0] = 6'(s);
    return w;
  endfunction

  function automatic logic [31:0] pk_date(int d, int mo, int y, bit lp);
    logic [31:0] w = '0;
    w[24] = lp; w[23:16] = 8'(y); w[11:8] = 4'(mo); w[4:0] = 5'(d);
    return w;
  endfunction

  function automatic logic [31:0] m_time();
    return pk_time(m_hr, m_min, m_sec);
  endfunction

  function automatic logic [31:0] m_date();
    return pk_date(m_day, m_mon, m_yr, m_leap);
  endfunction

  // ---------------- driver ----------------
  task automatic bus_rd(input logic [3:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick1();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    model_tick();
  endtask

  task automatic set_time(input int h, input int mi, input int s);
    bus_wr(A_TIME, pk_time(h, mi, s));
    m_hr = h; m_min = mi; m_sec = s;
    idle(CYC + 1);
  endtask

  task automatic set_date(input int d, input int mo, input int y, input bit lp);
    bus_wr(A_DATE, pk_date(d, mo, y, lp));
    m_day = d; m_mon = mo; m_yr = y; m_leap = lp;
    idle(CYC + 1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    if (rst_n && rvalid && !finished) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected read data: got %h expected none", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", t, rdata, e);
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] old_t;
    m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_mon = 1; m_yr = 0; m_leap = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    bus_rd(A_CTRL, 32'h0, "R1 ctrl reset");
    bus_rd(A_TIME, 32'h0, "R1 time reset");
    bus_rd(A_DATE, 32'h0000_0101, "R1 date reset");

    // R4 time commit window, cycle by cycle
    old_t = m_time();
    bus_wr(A_TIME, pk_time(23, 59, 58));
    bus_rd(A_CTRL, 32'h0000_0100, "R4 busy first cycle");
    bus_rd(A_TIME, old_t, "R4 old time during commit");
    for (int i = 0; i < CYC - 2; i++) bus_rd(A_CTRL, 32'h0000_0100, "R4 busy held");
    bus_rd(A_CTRL, 32'h0, "R4 busy cleared");
    m_hr = 23; m_min = 59; m_sec = 58;
    bus_rd(A_TIME, m_time(), "R4 committed time");

    // R5 date commit window, time flag untouched
    bus_wr(A_DATE, pk_date(28, 2, 5, 1'b0));
    for (int i = 0; i < CYC; i++) bus_rd(A_CTRL, 32'h0000_0080, "R5 date busy only");
    bus_rd(A_CTRL, 32'h0, "R5 date busy cleared");
    m_day = 28; m_mon = 2; m_yr = 5; m_leap = 1'b0;
    bus_rd(A_DATE, m_date(), "R5 committed date");

    // R3 plain step, R7 non-leap February end
    tick1();
    bus_rd(A_TIME, m_time(), "R3 second step");
    tick1();
    bus_rd(A_TIME, m_time(), "R3 day carry time");
    bus_rd(A_DATE, m_date(), "R7 non-leap Feb 28 to Mar 1");

    // R7 leap February
    set_date(28, 2, 5, 1'b1);
    set_time(23, 59, 59);
    tick1();
    bus_rd(A_DATE, m_date(), "R7 leap Feb 28 to 29");
    set_time(23, 59, 59);
    tick1();
    bus_rd(A_DATE, m_date(), "R7 leap Feb 29 to Mar 1 flag kept");

    // R3 minute and hour carries
    set_time(0, 0, 59);
    tick1();
    bus_rd(A_TIME, m_time(), "R3 minute carry");
    set_time(0, 59, 59);
    tick1();
    bus_rd(A_TIME, m_time(), "R3 hour carry");
    bus_rd(A_DATE, m_date(), "R3 date unchanged by hour carry");

    // R6 month lengths
    set_date(30, 4, 9, 1'b0);
    set_time(23, 59, 59);
    tick1();
    bus_rd(A_DATE, m_date(), "R6 30-day month end");
    set_date(30, 1, 9, 1'b0);
    set_time(23, 59, 59);
    tick1();
    bus_rd(A_DATE, m_date(), "R6 Jan 30 to 31");
    set_time(23, 59, 59);
    tick1();
    bus_rd(A_DATE, m_date(), "R6 31-day month end");

    // R8 year end
    set_date(31, 12, 7, 1'b0);
    set_time(23, 59, 59);
    tick1();
    bus_rd(A_DATE, m_date(), "R8 year step");
    set_date(31, 12, 255, 1'b0);
    set_time(23, 59, 59);
    tick1();
    bus_rd(A_DATE, m_date(), "R8 year offset wrap");
    bus_rd(A_TIME, m_time(), "R8 midnight");

    // R9 tick inside time commit window
    bus_wr(A_TIME, pk_time(10, 20, 30));
    m_hr = 10; m_min = 20; m_sec = 30;
    idle(1);
    tick1();
    idle(CYC + 2);
    bus_rd(A_TIME, m_time(), "R9 deferred tick on new time");

    // R9 tick inside date commit window
    set_time(23, 59, 59);
    bus_wr(A_DATE, pk_date(31, 3, 1, 1'b0));
    m_day = 31; m_mon = 3; m_yr = 1; m_leap = 1'b0;
    idle(1);
    tick1();
    idle(CYC + 2);
    bus_rd(A_DATE, m_date(), "R9 deferred tick on new date");
    bus_rd(A_TIME, m_time(), "R9 deferred tick time");

    // R10 ignored writes, R2 unmapped read
    bus_wr(A_CTRL, 32'hFFFF_FFFF);
    bus_rd(A_CTRL, 32'h0, "R10 ctrl write ignored");
    bus_wr(4'hC, 32'hFFFF_FFFF);
    bus_rd(4'hC, 32'h0, "R2 unmapped read zero");
    bus_rd(A_TIME, m_time(), "R10 time untouched");
    bus_rd(A_DATE, m_date(), "R10 date untouched");

    idle(3);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R2 missing read data: got %0d pending expected 0", exp_q.size());
    end
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule